// File: doc/BRIEF.md
# Multiplexed ADC Serial Port Logic

This block is the digital front end of a multiplexed analog-to-digital converter with a serial host port. A host drives an active-low chip select, a serial clock and a serial data line into the block. It reads the conversion result back on a serial data output, most significant bit first. A data-output-ready flag is low while a word is being shifted and high otherwise. All serial inputs are oversampled by the block's system clock, so every internal decision is made in one synchronous clock domain.

Every serial sequence carries a fixed number of serial clock pulses, equal to the current output word length (13 by default, 9 in the short mode). The first four input bits form a command: a conversion on a given channel, a calibration, an offset-zeroing pass, or a word-length change. The converter core is abstracted. The block issues a one-cycle start pulse with a channel address and waits for the core's end-of-conversion pulse with the result. Calibration and zeroing are modelled as fixed-length busy intervals.

A mode-select input chooses between programming cycles and read-only cycles. A read-only cycle only replays the stored result and leaves everything else untouched. Chip select can be toggled for each word or held low. When it is held low, the core's end-of-conversion pulse opens the next word. A chip-select fall during a conversion aborts it and marks the stored result as invalid. A power-down input stops all activity, and after release the block waits a power-up interval before it reports ready.

Top module: `adc_sp_port`

## Requirements
- R1: While reset is asserted and in the cycles after it, sdo_o is 0, dor_o is 1 and ready_o is 0. The stored result is 0 and the word length is 13.
- R2: While pwr_dn_i is high, ready_o is 0, dor_o is 1 and sdo_o is 0. After pwr_dn_i falls, ready_o stays 0 for PWRUP_CYC clock cycles and then goes to 1. The stored result and the word length are kept across power-down.
- R3: With ready_o high, a falling chip select while prog_n_i is 0 opens a sequence. dor_o goes low and sdo_o shows the stored result's MSB. Each serial clock falling edge presents the next bit. dor_o returns high after the word-length-th serial clock rising edge.
- R4: With chip select held low and no sequence open, the end of a conversion opens a sequence by itself. dor_o goes low and sdo_o shows the new result's MSB at once.
- R5: A command with leading bit 0 (four bits, MSB first, 0aaa) loads aaa into mux_addr_o and pulses conv_go_o for one cycle at the end of the sequence. The result is then taken from core_data_i when core_eoc_i arrives.
- R6: Command 1010 selects 13-bit words and command 1011 selects 9-bit words. In 9-bit mode the top 9 result bits are shifted out.
- R7: A chip-select fall while a conversion is pending cancels it. The previous result is kept, res_bad_o goes high, and a late core_eoc_i is ignored. The next completed conversion clears res_bad_o.
- R8: A sequence opened with prog_n_i at 1 is read-only. It replays the stored result and ignores sdi_i: no conv_go_o pulse, and no change to mux_addr_o or to the word length.
- R9: While a conversion, calibration or zeroing pass is pending, a chip-select fall with prog_n_i at 1 is ignored: no sequence opens and dor_o stays high.
- R10: Command 1000 starts a calibration busy interval of CAL_CYC cycles and command 1001 starts a zeroing busy interval of ZERO_CYC cycles.
- R11: Serial input bits are captured on serial clock rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial port |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial command input |
| prog_n_i | input | 1 | Low: programming cycles; high: read-only cycles |
| pwr_dn_i | input | 1 | High powers the block down |
| core_eoc_i | input | 1 | One-cycle end-of-conversion pulse from the core |
| core_data_i | input | MAX_W | Result delivered with core_eoc_i |
| sdo_o | output | 1 | Serial result output, MSB first |
| dor_o | output | 1 | Low while a word is shifting, high otherwise |
| ready_o | output | 1 | High once powered and warmed up |
| res_bad_o | output | 1 | Stored result came from an aborted conversion |
| conv_go_o | output | 1 | One-cycle conversion start pulse to the core |
| mux_addr_o | output | ADDR_W | Selected input channel |

## Verification
The bench cancels a conversion by toggling chip select before the core answers. It then checks that the old result is still shifted out and that the core's late answer changes nothing. A design that let the late pulse through would show new data or clear the invalid flag. Read-only cycles are sent with a conversion command on the input line, and a design that decoded them would move the channel address or emit a start pulse. Both 9-bit and 13-bit words are exercised, with the ready flag checked right after the last rising edge, so a miscounted word length shows up as a ready flag that is late or early. Chip select is also held low across a conversion, where a design that missed the end-of-conversion start would leave the ready flag high and the old MSB on the output.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

    typedef enum logic [1:0] {
        PM_OFF  = 2'd0,
        PM_WARM = 2'd1,
        PM_RUN  = 2'd2
    } pwr_mode_e;

    typedef enum logic [1:0] {
        BZ_NONE = 2'd0,
        BZ_CONV = 2'd1,
        BZ_CAL  = 2'd2,
        BZ_ZERO = 2'd3
    } busy_e;

endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
    parameter int unsigned       WIDTH   = 1,
    parameter int unsigned       STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[b]}};
            end else begin
                chain_q <= chain_d;
            end
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/adc_sp_timer.sv
module adc_sp_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          done_o
);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == CW'(1)) && !load_i;

endmodule

// File: rtl/adc_sp_port.sv
module adc_sp_port
    import adc_sp_pkg::*;
#(
    parameter int unsigned MAX_W       = 13,
    parameter int unsigned SHORT_W     = 9,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PWRUP_CYC   = 12500,
    parameter int unsigned CAL_CYC     = 200,
    parameter int unsigned ZERO_CYC    = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              prog_n_i,
    input  logic              pwr_dn_i,
    input  logic              core_eoc_i,
    input  logic [MAX_W-1:0]  core_data_i,
    output logic              sdo_o,
    output logic              dor_o,
    output logic              ready_o,
    output logic              res_bad_o,
    output logic              conv_go_o,
    output logic [ADDR_W-1:0] mux_addr_o
);

    localparam int unsigned CMD_W   = ADDR_W + 1;
    localparam int unsigned CNT_W   = $clog2(MAX_W + 1);
    localparam int unsigned TMR_MAX = (PWRUP_CYC > CAL_CYC)
                                      ? ((PWRUP_CYC > ZERO_CYC) ? PWRUP_CYC : ZERO_CYC)
                                      : ((CAL_CYC > ZERO_CYC) ? CAL_CYC : ZERO_CYC);
    localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

    localparam logic [CMD_W-1:0] OP_CAL   = CMD_W'((1 << ADDR_W) + 0);
    localparam logic [CMD_W-1:0] OP_ZERO  = CMD_W'((1 << ADDR_W) + 1);
    localparam logic [CMD_W-1:0] OP_LONG  = CMD_W'((1 << ADDR_W) + 2);
    localparam logic [CMD_W-1:0] OP_SHORT = CMD_W'((1 << ADDR_W) + 3);

    typedef struct packed {
        pwr_mode_e          mode;
        busy_e              busy;
        logic               seq_on;
        logic               seq_ro;
        logic [CNT_W-1:0]   bit_cnt;
        logic [CNT_W-1:0]   word_len;
        logic [MAX_W-1:0]   osh;
        logic [CMD_W-1:0]   ish;
        logic               sdo;
        logic [MAX_W-1:0]   res;
        logic               res_bad;
        logic [ADDR_W-1:0]  chan;
        logic               go;
        logic               cs_prev;
        logic               sclk_prev;
    } port_st_t;

    // synchronised copies of the host-side pins
    logic [4:0] pins_async;
    logic [4:0] pins_sync;
    logic       s_cs;
    logic       s_sclk;
    logic       s_sdi;
    logic       s_prog;
    logic       s_pd;

    assign pins_async = {pwr_dn_i, prog_n_i, sdi_i, sclk_i, cs_n_i};

    adc_sp_sync #(
        .WIDTH   (5),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (5'b01001)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_async),
        .sync_o  (pins_sync)
    );

    assign s_cs   = pins_sync[0];
    assign s_sclk = pins_sync[1];
    assign s_sdi  = pins_sync[2];
    assign s_prog = pins_sync[3];
    assign s_pd   = pins_sync[4];

    // one shared interval timer: warm-up, calibration, zeroing
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_done;

    adc_sp_timer #(
        .CW (TMR_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .done_o (tmr_done)
    );

    port_st_t st_d;
    port_st_t st_q;

    logic             cs_fall;
    logic             cs_rise;
    logic             sck_rise;
    logic             sck_fall;
    logic             last_edge;
    logic [CMD_W-1:0] ish_cap;

    always_comb begin
        cs_fall   = st_q.cs_prev & ~s_cs;
        cs_rise   = ~st_q.cs_prev & s_cs;
        sck_rise  = ~st_q.sclk_prev & s_sclk;
        sck_fall  = st_q.sclk_prev & ~s_sclk;
        last_edge = (CNT_W'(st_q.bit_cnt + 1'b1) == st_q.word_len);
        ish_cap   = (st_q.bit_cnt < CNT_W'(CMD_W))
                    ? {st_q.ish[CMD_W-2:0], s_sdi} : st_q.ish;
    end

    always_comb begin
        st_d           = st_q;
        st_d.go        = 1'b0;
        st_d.cs_prev   = s_cs;
        st_d.sclk_prev = s_sclk;
        tmr_load       = 1'b0;
        tmr_val        = '0;

        case (st_q.mode)
            PM_OFF: begin
                if (!s_pd) begin
                    st_d.mode = PM_WARM;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(PWRUP_CYC);
                end
            end

            PM_WARM: begin
                if (s_pd) begin
                    st_d.mode = PM_OFF;
                end else if (tmr_done) begin
                    st_d.mode = PM_RUN;
                end
            end

            PM_RUN: begin
                if (s_pd) begin
                    st_d.mode   = PM_OFF;
                    st_d.busy   = BZ_NONE;
                    st_d.seq_on = 1'b0;
                    st_d.sdo    = 1'b0;
                end else begin
                    // converter core reports a finished result
                    if (st_q.busy == BZ_CONV && core_eoc_i) begin
                        st_d.res     = core_data_i;
                        st_d.res_bad = 1'b0;
                        st_d.busy    = BZ_NONE;
                        if (!s_cs && !st_q.seq_on) begin
                            st_d.seq_on  = 1'b1;
                            st_d.seq_ro  = s_prog;
                            st_d.bit_cnt = '0;
                            st_d.ish     = '0;
                            st_d.osh     = core_data_i;
                            st_d.sdo     = core_data_i[MAX_W-1];
                        end
                    end

                    // timed busy intervals run out
                    if ((st_q.busy == BZ_CAL || st_q.busy == BZ_ZERO) && tmr_done) begin
                        st_d.busy = BZ_NONE;
                    end

                    // serial clock activity inside an open sequence
                    if (st_q.seq_on && !s_cs) begin
                        if (sck_fall) begin
                            st_d.osh = st_q.osh << 1;
                            st_d.sdo = st_q.osh[MAX_W-2];
                        end
                        if (sck_rise) begin
                            if (!st_q.seq_ro) begin
                                st_d.ish = ish_cap;
                            end
                            st_d.bit_cnt = CNT_W'(st_q.bit_cnt + 1'b1);
                            if (last_edge) begin
                                st_d.seq_on = 1'b0;
                                if (!st_q.seq_ro) begin
                                    if (!ish_cap[CMD_W-1]) begin
                                        st_d.chan = ish_cap[ADDR_W-1:0];
                                        st_d.busy = BZ_CONV;
                                        st_d.go   = 1'b1;
                                    end else begin
                                        case (ish_cap)
                                            OP_CAL: begin
                                                st_d.busy = BZ_CAL;
                                                tmr_load  = 1'b1;
                                                tmr_val   = TMR_W'(CAL_CYC);
                                            end
                                            OP_ZERO: begin
                                                st_d.busy = BZ_ZERO;
                                                tmr_load  = 1'b1;
                                                tmr_val   = TMR_W'(ZERO_CYC);
                                            end
                                            OP_LONG:  st_d.word_len = CNT_W'(MAX_W);
                                            OP_SHORT: st_d.word_len = CNT_W'(SHORT_W);
                                            default:  ;
                                        endcase
                                    end
                                end
                            end
                        end
                    end

                    // chip select released: sequence is abandoned
                    if (cs_rise) begin
                        st_d.seq_on = 1'b0;
                    end

                    // chip select asserted: new sequence, cancels pending work
                    if (cs_fall && !(s_prog && st_d.busy != BZ_NONE)) begin
                        if (st_d.busy == BZ_CONV) begin
                            st_d.res_bad = 1'b1;
                        end
                        st_d.busy    = BZ_NONE;
                        st_d.seq_on  = 1'b1;
                        st_d.seq_ro  = s_prog;
                        st_d.bit_cnt = '0;
                        st_d.ish     = '0;
                        st_d.osh     = st_d.res;
                        st_d.sdo     = st_d.res[MAX_W-1];
                    end
                end
            end

            default: st_d.mode = PM_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode      <= PM_OFF;
            st_q.busy      <= BZ_NONE;
            st_q.seq_on    <= 1'b0;
            st_q.seq_ro    <= 1'b0;
            st_q.bit_cnt   <= '0;
            st_q.word_len  <= CNT_W'(MAX_W);
            st_q.osh       <= '0;
            st_q.ish       <= '0;
            st_q.sdo       <= 1'b0;
            st_q.res       <= '0;
            st_q.res_bad   <= 1'b0;
            st_q.chan      <= '0;
            st_q.go        <= 1'b0;
            st_q.cs_prev   <= 1'b1;
            st_q.sclk_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo_o      = st_q.sdo;
    assign dor_o      = ~st_q.seq_on;
    assign ready_o    = (st_q.mode == PM_RUN);
    assign res_bad_o  = st_q.res_bad;
    assign conv_go_o  = st_q.go;
    assign mux_addr_o = st_q.chan;

endmodule

// File: rtl/adc_sp_port_chk.sv
module adc_sp_port_chk #(
    parameter int unsigned MAX_W  = 13,
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_i,
    input logic              prog_n_i,
    input logic              pwr_dn_i,
    input logic              core_eoc_i,
    input logic [MAX_W-1:0]  core_data_i,
    input logic              sdo_o,
    input logic              dor_o,
    input logic              ready_o,
    input logic              res_bad_o,
    input logic              conv_go_o,
    input logic [ADDR_W-1:0] mux_addr_o
);

    AST_IDLE_WHEN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> (dor_o && !sdo_o)); // R2

    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go_o |=> !conv_go_o); // R5

    AST_GO_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go_o |-> (dor_o && ready_o)); // R3

    AST_ADDR_ONLY_ON_GO: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_go_o |-> (mux_addr_o == $past(mux_addr_o))); // R5

    AST_ABORT_OPENS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_bad_o) |-> !dor_o); // R7

    AST_GO_NEEDS_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_go_o) |-> ready_o); // R8

endmodule

bind adc_sp_port adc_sp_port_chk #(
    .MAX_W  (MAX_W),
    .ADDR_W (ADDR_W)
) chk_i (.*);

// File: tb/adc_sp_port_tb_top.sv
module adc_sp_port_tb_top;

    localparam int MAX_W    = 13;
    localparam int PWRUP    = 12500;
    localparam int CAL_CYC  = 200;
    localparam int ZERO_CYC = 60;
    localparam int CONV_LAT = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        prog_n = 1'b0;
    logic        pwr_dn = 1'b0;
    logic        core_eoc = 1'b0;
    logic [12:0] core_data = '0;
    logic        sdo;
    logic        dor;
    logic        ready;
    logic        res_bad;
    logic        conv_go;
    logic [2:0]  mux_addr;

    int total = 0;
    int bad = 0;
    int go_cnt = 0;
    int conv_n = 0;
    logic [12:0] last_data = '0;
    logic [12:0] m_res = '0;
    logic [12:0] got;
    bit finished = 0;

    always #10 clk = ~clk;

    adc_sp_port dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_i      (cs_n),
        .sclk_i      (sclk),
        .sdi_i       (sdi),
        .prog_n_i    (prog_n),
        .pwr_dn_i    (pwr_dn),
        .core_eoc_i  (core_eoc),
        .core_data_i (core_data),
        .sdo_o       (sdo),
        .dor_o       (dor),
        .ready_o     (ready),
        .res_bad_o   (res_bad),
        .conv_go_o   (conv_go),
        .mux_addr_o  (mux_addr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // abstract converter core: answers each start pulse after CONV_LAT cycles
    initial begin
        forever begin
            @(negedge clk);
            if (conv_go) begin
                logic [2:0] a;
                a = mux_addr;
                go_cnt++;
                clks(CONV_LAT);
                core_data = 13'h0A5C ^ 13'(conv_n * 'h391) ^ {a, 10'h0};
                last_data = core_data;
                core_eoc  = 1'b1;
                conv_n++;
                @(negedge clk);
                core_eoc  = 1'b0;
            end
        end
    end

    // one serial word; got holds the bits read, MSB first, right-aligned
    task automatic xfer(input logic [3:0] cmd, input int nb, input logic ro,
                        input bit toggle, output logic [12:0] word, input string tag);
        prog_n = ro;
        clks(4);
        if (toggle) begin
            cs_n = 1'b0;
            clks(8);
        end
        word = '0;
        for (int i = 0; i < nb; i++) begin
            sdi = (i < 4) ? cmd[3-i] : 1'b0;
            clks(5);
            word = {word[11:0], sdo};
            if (i == nb / 2) chk(dor == 1'b0, {tag, " dor low mid-word"}, dor, 0);
            sclk = 1'b1;
            clks(6);
            sclk = 1'b0;
            clks(6);
        end
        chk(dor == 1'b1, {tag, " dor high after last rise"}, dor, 1);
        if (toggle) begin
            cs_n = 1'b1;
            clks(8);
        end
        prog_n = 1'b0;
    endtask

    initial begin
        clks(150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int g0;
        clks(5);
        // R1 reset state
        chk(sdo == 0 && dor == 1 && ready == 0, "R1 reset outputs", {sdo, dor, ready}, 3'b010);
        rst_n = 1'b1;
        clks(200);
        chk(ready == 0 && dor == 1, "R2 warm-up not ready", ready, 0);
        clks(PWRUP);
        chk(ready == 1, "R2 ready after warm-up", ready, 1);

        // R3/R5/R11 conversion command on channel 5, reads reset result
        xfer(4'b0101, 13, 1'b0, 1'b1, got, "R3");
        chk(got == 13'h0, "R1 R3 first word is reset result", got, 0);
        chk(mux_addr == 3'd5, "R5 R11 channel address", mux_addr, 5);
        chk(go_cnt == 1, "R5 one start pulse", go_cnt, 1);
        clks(CONV_LAT + 10);
        m_res = last_data;

        // R8 read-only replays result, ignores a conversion command on sdi
        g0 = go_cnt;
        xfer(4'b0010, 13, 1'b1, 1'b1, got, "R8");
        chk(got == m_res, "R3 R8 read-only replay", got, m_res);
        clks(CONV_LAT + 10);
        chk(go_cnt == g0 && mux_addr == 3'd5, "R8 no start, address kept", mux_addr, 5);

        // R6 short words
        xfer(4'b1011, 13, 1'b0, 1'b1, got, "R6 set short");
        xfer(4'b0011, 9, 1'b0, 1'b1, got, "R6 short conv");
        chk(got == {4'h0, m_res[12:4]}, "R6 top nine bits", got, m_res[12:4]);
        clks(CONV_LAT + 10);
        m_res = last_data;
        xfer(4'b0000, 9, 1'b1, 1'b1, got, "R6 short read");
        chk(got == {4'h0, m_res[12:4]}, "R6 short replay", got, m_res[12:4]);
        xfer(4'b1010, 9, 1'b0, 1'b1, got, "R6 set long");
        xfer(4'b1111, 13, 1'b1, 1'b1, got, "R6 long read");
        chk(got == m_res, "R6 long replay", got, m_res);

        // R4 chip select held low across a conversion
        prog_n = 1'b0;
        clks(4);
        cs_n = 1'b0;
        clks(8);
        xfer(4'b0110, 13, 1'b0, 1'b0, got, "R4 cmd");
        clks(CONV_LAT + 10);
        m_res = last_data;
        chk(dor == 1'b0, "R4 eoc opens word", dor, 0);
        chk(sdo == m_res[12], "R4 first bit at eoc", sdo, m_res[12]);
        xfer(4'b1111, 13, 1'b0, 1'b0, got, "R4 read");
        chk(got == m_res, "R4 continuous word", got, m_res);
        cs_n = 1'b1;
        clks(8);

        // R7 abort by chip select during conversion
        xfer(4'b0001, 13, 1'b0, 1'b1, got, "R7 cmd");
        cs_n = 1'b0;
        clks(10);
        chk(res_bad == 1'b1, "R7 abort flags result", res_bad, 1);
        clks(CONV_LAT + 20);
        chk(res_bad == 1'b1 && dor == 1'b0, "R7 late eoc ignored", res_bad, 1);
        xfer(4'b1111, 13, 1'b0, 1'b0, got, "R7 read");
        chk(got == m_res, "R7 old result kept", got, m_res);
        cs_n = 1'b1;
        clks(8);
        xfer(4'b0010, 13, 1'b0, 1'b1, got, "R7 new conv");
        clks(CONV_LAT + 10);
        m_res = last_data;
        chk(res_bad == 1'b0, "R7 flag cleared by completed conversion", res_bad, 0);

        // R9 R10 calibration busy interval refuses read-only cycles
        xfer(4'b1000, 13, 1'b0, 1'b1, got, "R10 cal");
        prog_n = 1'b1;
        clks(4);
        cs_n = 1'b0;
        clks(10);
        chk(dor == 1'b1, "R9 read-only refused during calibration", dor, 1);
        cs_n = 1'b1;
        clks(CAL_CYC + 20);
        xfer(4'b0000, 13, 1'b1, 1'b1, got, "R10 after cal");
        chk(got == m_res, "R10 read accepted after calibration", got, m_res);

        // R9 R10 zeroing interval
        xfer(4'b1001, 13, 1'b0, 1'b1, got, "R10 zero");
        prog_n = 1'b1;
        clks(4);
        cs_n = 1'b0;
        clks(10);
        chk(dor == 1'b1, "R9 read-only refused during zeroing", dor, 1);
        cs_n = 1'b1;
        clks(ZERO_CYC + 20);
        xfer(4'b0000, 13, 1'b1, 1'b1, got, "R10 after zero");
        chk(got == m_res, "R10 read accepted after zeroing", got, m_res);

        // R2 power-down and recovery
        pwr_dn = 1'b1;
        clks(6);
        chk(ready == 0 && dor == 1 && sdo == 0, "R2 powered down", {ready, dor, sdo}, 3'b010);
        pwr_dn = 1'b0;
        clks(100);
        chk(ready == 1'b0, "R2 warm-up after power-down", ready, 0);
        clks(PWRUP);
        chk(ready == 1'b1, "R2 ready again", ready, 1);
        xfer(4'b0000, 13, 1'b1, 1'b1, got, "R2 read");
        chk(got == m_res, "R2 result kept across power-down", got, m_res);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule